// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Unit

This unit executes the four partial-word memory instructions of a 32-bit little-endian core. The two loads fill the high or the low part of a register. The two stores update the high or the low part of a memory word. A request supplies a byte address, the register operand, the destination register index and an operation code. The unit only ever sends the word-aligned address to its memory port. The low two address bits pick the byte shift and the mask that combine register bytes with memory bytes.

Loads read the aligned word once. They merge it into the latched register value and return the result with a write-back enable. Stores do a read-modify-write: they read the aligned word, merge the register bytes into it, and write it back to the same address. Requests are accepted only while the unit is idle. Every operand is captured when a request is accepted.

Top module: `pw_top`

## Requirements
- R1: Every memory read and write uses the address with bits [1:0] cleared. The byte offset used by the merge is addr[1:0] as captured at start.
- R2: op=0 (fill high part): the result keeps memory byte j at register byte j+3-off for j<=off; every other byte comes from the register. Example: mem 0x11223344, reg 0xAABBCCDD, off 1 gives 0x3344CCDD.
- R3: op=1 (fill low part): register byte i takes memory byte i+off for i<=3-off; every other byte comes from the register. Example, same operands, off 1: 0xAA112233.
- R4: op=2 (store high part): the written word has register byte i+3-off at byte i for i<=off; every other byte keeps the memory value. Example, off 1: 0x1122AABB.
- R5: op=3 (store low part): the written word has register byte i-off at byte i for i>=off; every other byte keeps the memory value. Example, off 1: 0xBBCCDD44.
- R6: mem_rdata is valid the cycle after mem_rd. Every operation makes exactly one read. A store makes exactly one write, two cycles after its read, to the same address. A load makes no write.
- R7: done is a one-cycle pulse. It comes 3 cycles after the accepting clock edge for a load and 4 cycles after it for a store. busy is high from the cycle after acceptance through the done cycle.
- R8: During done, reg_we is 1 only for a load whose register index is not 0, and wb_idx carries that index. Stores never raise reg_we. result carries the merged word: the load result, or the word a store wrote.
- R9: op, addr, reg_val and reg_idx are captured at acceptance. Later changes to them do not alter the operation. A start pulse while busy is ignored.
- R10: After reset, busy, done, reg_we, mem_rd and mem_wr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; accepted when not busy |
| op | input | 2 | 0 fill-high load, 1 fill-low load, 2 store-high, 3 store-low |
| addr | input | AW | Byte address |
| reg_val | input | 32 | Register operand (load destination old value / store source) |
| reg_idx | input | 5 | Destination register index for loads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| result | output | 32 | Merged word |
| reg_we | output | 1 | Register write-back enable, valid with done |
| wb_idx | output | 5 | Write-back register index |
| mem_addr | output | AW | Word-aligned memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after mem_rd |

## Verification
The assertions check the protocol rules on every cycle. These are address alignment, no read and write in the same cycle, a write that follows its read by two cycles at the same address, the single-cycle done pulse, the start-to-read step, and the write-back rules for register index 0. Byte-merge correctness for each operation and offset needs a memory and known operands, so only the bench's vector walk shows it. The bench also shows the exact latencies, the count of accesses, and that operands changed or a second start given mid-operation have no effect.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int OFFW = $clog2(NB);

  typedef enum logic [1:0] {
    OP_FILL_HI  = 2'd0,
    OP_FILL_LO  = 2'd1,
    OP_STORE_HI = 2'd2,
    OP_STORE_LO = 2'd3
  } pw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_LATCH = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } pw_state_e;

  function automatic logic is_store(pw_op_e o);
    return o[1];
  endfunction

  // Load filling the upper bytes: memory low bytes slide to the top.
  function automatic logic [DW-1:0] fill_hi(logic [DW-1:0] mem, logic [DW-1:0] rv,
                                            logic [OFFW-1:0] off);
    logic [DW-1:0] r;
    r = rv;
    for (int i = 0; i < NB; i++) begin
      if (i >= NB - 1 - int'(off))
        r[8*i +: 8] = mem[8*((i - (NB - 1 - int'(off))) % NB) +: 8];
    end
    return r;
  endfunction

  // Load filling the lower bytes: memory high bytes slide to the bottom.
  function automatic logic [DW-1:0] fill_lo(logic [DW-1:0] mem, logic [DW-1:0] rv,
                                            logic [OFFW-1:0] off);
    logic [DW-1:0] r;
    r = rv;
    for (int i = 0; i < NB; i++) begin
      if (i <= NB - 1 - int'(off))
        r[8*i +: 8] = mem[8*((i + int'(off)) % NB) +: 8];
    end
    return r;
  endfunction

  // Store of the register's upper bytes into the low end of the word.
  function automatic logic [DW-1:0] put_hi(logic [DW-1:0] mem, logic [DW-1:0] rv,
                                           logic [OFFW-1:0] off);
    logic [DW-1:0] r;
    r = mem;
    for (int i = 0; i < NB; i++) begin
      if (i <= int'(off))
        r[8*i +: 8] = rv[8*((i + NB - 1 - int'(off)) % NB) +: 8];
    end
    return r;
  endfunction

  // Store of the register's lower bytes into the high end of the word.
  function automatic logic [DW-1:0] put_lo(logic [DW-1:0] mem, logic [DW-1:0] rv,
                                           logic [OFFW-1:0] off);
    logic [DW-1:0] r;
    r = mem;
    for (int i = 0; i < NB; i++) begin
      if (i >= int'(off))
        r[8*i +: 8] = rv[8*((i - int'(off) + NB) % NB) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/pw_merge.sv
module pw_merge
  import pw_pkg::*;
(
  input  pw_op_e          op,
  input  logic [OFFW-1:0] off,
  input  logic [DW-1:0]   mem_word,
  input  logic [DW-1:0]   reg_word,
  output logic [DW-1:0]   merged
);
  always_comb begin
    unique case (op)
      OP_FILL_HI:  merged = fill_hi(mem_word, reg_word, off);
      OP_FILL_LO:  merged = fill_lo(mem_word, reg_word, off);
      OP_STORE_HI: merged = put_hi(mem_word, reg_word, off);
      default:     merged = put_lo(mem_word, reg_word, off);
    endcase
  end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      store_q,
  output logic      accept,
  output logic      in_read,
  output logic      in_latch,
  output logic      in_write,
  output logic      in_done,
  output logic      busy
);
  pw_state_e state_q, state_d;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_LATCH;
      ST_LATCH: state_d = store_q ? ST_WRITE : ST_DONE;
      ST_WRITE: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign in_read  = (state_q == ST_READ);
  assign in_latch = (state_q == ST_LATCH);
  assign in_write = (state_q == ST_WRITE);
  assign in_done  = (state_q == ST_DONE);
  assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/pw_top.sv
module pw_top
  import pw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      reg_val,
  input  logic [IDX_W-1:0] reg_idx,
  output logic             busy,
  output logic             done,
  output logic [31:0]      result,
  output logic             reg_we,
  output logic [IDX_W-1:0] wb_idx,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata
);
  pw_op_e           op_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    reg_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    res_q;
  logic [DW-1:0]    merged;

  // Named internal events, visible to the bound checker.
  logic accept, in_read, in_latch, in_write, in_done;
  logic store_q;

  assign store_q = is_store(op_q);

  pw_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .store_q  (store_q),
    .accept   (accept),
    .in_read  (in_read),
    .in_latch (in_latch),
    .in_write (in_write),
    .in_done  (in_done),
    .busy     (busy)
  );

  pw_merge u_merge (
    .op       (op_q),
    .off      (addr_q[OFFW-1:0]),
    .mem_word (mem_rdata),
    .reg_word (reg_q),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_FILL_HI;
      addr_q <= '0;
      reg_q  <= '0;
      idx_q  <= '0;
      res_q  <= '0;
    end else begin
      if (accept) begin
        op_q   <= pw_op_e'(op);
        addr_q <= addr;
        reg_q  <= reg_val;
        idx_q  <= reg_idx;
      end
      if (in_latch) res_q <= merged;
    end
  end

  assign mem_addr  = {addr_q[AW-1:OFFW], {OFFW{1'b0}}};
  assign mem_rd    = in_read;
  assign mem_wr    = in_write;
  assign mem_wdata = res_q;
  assign done      = in_done;
  assign result    = res_q;
  assign wb_idx    = idx_q;
  assign reg_we    = in_done && !store_q && (idx_q != '0);
endmodule

// File: rtl/pw_chk.sv
module pw_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic             done,
  input logic             reg_we,
  input logic [IDX_W-1:0] wb_idx,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rd,
  input logic             mem_wr
);
  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

  assert_accept_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_rd);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_we_rules_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (done && wb_idx != '0));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
endmodule

bind pw_top pw_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .busy     (busy),
  .done     (done),
  .reg_we   (reg_we),
  .wb_idx   (wb_idx),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/tb_pw_top.sv
module tb_pw_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [1:0]  op = 0;
  logic [31:0] addr = 0;
  logic [31:0] reg_val = 0;
  logic [4:0]  reg_idx = 0;
  logic        busy, done, reg_we, mem_rd, mem_wr;
  logic [31:0] result, mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic [4:0]  wb_idx;

  always #10 clk = ~clk;

  pw_top dut (.*);

  // Memory model: 16 words, read data one cycle after strobe.
  logic [31:0] mem [0:15];
  logic        poke_en = 0;
  logic [3:0]  poke_a = 0;
  logic [31:0] poke_d = 0;
  int rd_cnt = 0, wr_cnt = 0, misalign = 0;
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[5:2]];
    if (mem_wr) mem[mem_addr[5:2]] <= mem_wdata;
    if (poke_en) mem[poke_a] <= poke_d;
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    if (mem_wr) wr_cnt <= wr_cnt + 1;
    if ((mem_rd || mem_wr) && mem_addr[1:0] != 2'b00) misalign <= misalign + 1;
  end

  int errs = 0, checks = 0;
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk); poke_en = 1; poke_a = a[3:0]; poke_d = d;
    @(negedge clk); poke_en = 0;
  endtask

  // Run one operation; returns latency, result and reg_we seen at done.
  int lat; logic [31:0] res_seen; logic we_seen; logic [4:0] idx_seen;
  task automatic run(logic [1:0] o, logic [31:0] a, logic [31:0] r, logic [4:0] ix,
                     bit disturb);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    op = o; addr = a; reg_val = r; reg_idx = ix; start = 1;
    @(negedge clk);
    start = 0; lat = 1;
    if (disturb) begin
      start = 1; op = ~o; addr = a + 1; reg_val = ~r; reg_idx = ix + 1;
    end
    while (!done && lat < 20) begin
      @(negedge clk); lat++;
      start = 0;
    end
    res_seen = result; we_seen = reg_we; idx_seen = wb_idx;
    @(negedge clk);
    chk("R7 done pulse width", {31'd0, done}, 32'd0);
  endtask

  typedef struct packed { logic [1:0] o; logic [1:0] off; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [16] = '{
    '{2'd0, 2'd0, 32'h44BBCCDD}, '{2'd0, 2'd1, 32'h3344CCDD},
    '{2'd0, 2'd2, 32'h223344DD}, '{2'd0, 2'd3, 32'h11223344},
    '{2'd1, 2'd0, 32'h11223344}, '{2'd1, 2'd1, 32'hAA112233},
    '{2'd1, 2'd2, 32'hAABB1122}, '{2'd1, 2'd3, 32'hAABBCC11},
    '{2'd2, 2'd0, 32'h112233AA}, '{2'd2, 2'd1, 32'h1122AABB},
    '{2'd2, 2'd2, 32'h11AABBCC}, '{2'd2, 2'd3, 32'hAABBCCDD},
    '{2'd3, 2'd0, 32'hAABBCCDD}, '{2'd3, 2'd1, 32'hBBCCDD44},
    '{2'd3, 2'd2, 32'hCCDD3344}, '{2'd3, 2'd3, 32'hDD223344}
  };

  localparam logic [31:0] MEMW = 32'h11223344;
  localparam logic [31:0] REGW = 32'hAABBCCDD;

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'd0, busy}, 0);
    chk("R10 done", {31'd0, done}, 0);
    chk("R10 strobes", {30'd0, mem_rd, mem_wr}, 0);
    chk("R10 reg_we", {31'd0, reg_we}, 0);
    rst_n = 1;

    foreach (VECS[k]) begin
      string tag;
      tag = (VECS[k].o == 0) ? "R2" : (VECS[k].o == 1) ? "R3" :
            (VECS[k].o == 2) ? "R4" : "R5";
      poke(3, MEMW);
      run(VECS[k].o, 32'h0000_000C + {30'd0, VECS[k].off}, REGW, 5'd7, 0);
      chk($sformatf("%s result op%0d off%0d", tag, VECS[k].o, VECS[k].off),
          res_seen, VECS[k].exp);
      chk("R6 read count", rd_cnt, 1);
      if (VECS[k].o[1]) begin
        chk({tag, " memory word"}, mem[3], VECS[k].exp);
        chk("R6 write count", wr_cnt, 1);
        chk("R7 store latency", lat, 4);
        chk("R8 store no we", {31'd0, we_seen}, 0);
      end else begin
        chk("R6 load leaves memory", mem[3], MEMW);
        chk("R6 load no write", wr_cnt, 0);
        chk("R7 load latency", lat, 3);
        chk("R8 load we", {31'd0, we_seen}, 1);
        chk("R8 wb index", {27'd0, idx_seen}, 7);
      end
    end
    chk("R1 aligned accesses", misalign, 0);

    // R8: load to register 0 reads memory but writes no register
    poke(5, 32'hCAFEF00D);
    run(2'd1, 32'h0000_0016, 32'h01020304, 5'd0, 0);
    chk("R8 idx0 no we", {31'd0, we_seen}, 0);
    chk("R8 idx0 still reads", rd_cnt, 1);
    chk("R3 idx0 result", res_seen, 32'h0102CAFE);

    // R9: operands change and start repeats while busy
    poke(6, 32'h55667788);
    run(2'd3, 32'h0000_0019, 32'h0A0B0C0D, 5'd4, 1);
    chk("R9 result unchanged", res_seen, 32'h0B0C0D88);
    chk("R9 memory word", mem[6], 32'h0B0C0D88);
    chk("R9 single read", rd_cnt, 1);
    chk("R9 single write", wr_cnt, 1);
    repeat (2) @(negedge clk);
    chk("R9 no extra op", {31'd0, busy}, 0);

    // R1: a different word on the other side of the offset
    poke(9, 32'hDEADBEEF);
    run(2'd0, 32'h0000_0027, 32'h12345678, 5'd2, 0);
    chk("R1 R2 word 9 off3", res_seen, 32'hDEADBEEF);
    chk("R1 aligned final", misalign, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule